// File: doc/BRIEF.md
# Pulse Accumulator with Status Flags

An 8-bit event and gated-time accumulator for a microcontroller timer subsystem. An external pin is brought through a two-stage synchronizer. In event mode every selected edge of the pin adds one to the count. In gated mode the count advances once per tick of a divide-by-64 internal time base, but only while the pin sits at its active level. A polarity input chooses the rising or falling edge in event mode, and the high or low active level in gated mode.

Software reaches three byte-wide registers over a simple synchronous bus: the count, an interrupt enable register and a status flag register. Two flags are kept. One records a count wrap from 0xFF to 0x00. The other records an input edge: the chosen edge in event mode, or the end of the gate in gated mode. Each flag clears only when a one is written to its bit. One interrupt request output combines the flags with their enables. The count has no reset, so its value survives a chip reset. Count updates happen on the rising clock edge. Read data is captured on the falling edge, so a read always sees a settled count.

Top module: `pulse_accum`

## Requirements
- R1: Register address 0 holds the 8-bit count. It can be written and read at any time. A write in the same cycle as an increment stores the written value, and that increment is lost.
- R2: Reset clears the enable register (address 1) and the flag register (address 2) to 0x00. Reset leaves the count unchanged.
- R3: In event mode (`cfg_gated`=0), the count rises by one for each chosen edge of the synchronized pin. `cfg_active_high`=1 selects rising edges and 0 selects falling edges. The pin passes through two flops before edge detection.
- R4: In gated mode (`cfg_gated`=1), the count rises by one on each time-base tick while the synchronized pin is at its active level (high when `cfg_active_high`=1). A tick occurs every 64 clocks, counted from reset release. While the gate is inactive the count holds and stays readable.
- R5: Flag register bit 5 (wrap flag) sets whenever an increment takes the count from 0xFF to 0x00.
- R6: Writing a one to flag bit 5 or bit 4 clears that flag, and writing a zero leaves it. A set event in the same cycle as a clear leaves the flag set.
- R7: Flag register bit 4 (edge flag) sets on the chosen edge in event mode, and on the edge that ends the active level in gated mode.
- R8: `irq` = (flag bit 5 AND enable bit 5) OR (flag bit 4 AND enable bit 4). Writing the enable register never changes a flag.
- R9: Enable register bits 5, 4, 1 and 0 are writable (bits 1:0 hold a stored prescaler select). Its bits 7:6 and 3:2 read as zero. Flag register bits other than 5 and 4 read as zero. Address 3 reads 0x00.
- R10: `bus_rdata` is loaded on the falling clock edge from the register chosen by `bus_addr`. It shows the state left by the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External event or gate pin, asynchronous |
| cfg_gated | input | 1 | 1 selects gated-time mode, 0 selects event mode |
| cfg_active_high | input | 1 | 1 selects rising edge / high level, 0 selects falling edge / low level |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 2 | Register select: 0 count, 1 enables, 2 flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, loaded on the falling edge |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench holds a count write across many gated ticks. A design that let the increment win would show a count one above the written value. It issues a write-one-to-clear in the exact cycle the synchronized edge arrives. A design where the clear wins would lose that edge event. It pulses reset after loading a known count, which exposes any reset path on the count. It also swaps polarity and mode between bursts, so that a swapped edge choice or a gate that ends on the wrong edge shows up as a wrong count or flag.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam int WRAP_BIT = 5;
  localparam int EDGE_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_COUNT = 2'd0,
    RA_ENAB  = 2'd1,
    RA_FLAG  = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;

  // bits of the enable register that hold state
  localparam logic [DATA_W-1:0] ENAB_KEEP = 8'h33;

  // Chosen edge between current and previous synchronized samples
  function automatic logic pick_edge(logic cur, logic prev, logic want_rise);
    logic r, f;
    r = cur & ~prev;
    f = ~cur & prev;
    return want_rise ? r : f;
  endfunction

  // Gate active: sampled level equals the active level
  function automatic logic gate_on(logic cur, logic active_high);
    return cur == active_high;
  endfunction

  // Increment of a count that may wrap
  function automatic logic [CNT_W-1:0] bump(logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic at_top(logic [CNT_W-1:0] c);
    return &c;
  endfunction

  // Sticky flag: set dominates clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic lvl,
  output logic lvl_prev
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], pin_in};
  end

  assign lvl      = shreg[STAGES-1];
  assign lvl_prev = shreg[STAGES];
endmodule

// File: rtl/pa_tbase.sv
module pa_tbase #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] div_q;

  assign tick = (div_q == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + PW'(1);
  end
endmodule

// File: rtl/pa_counter.sv
module pa_counter
  import pa_pkg::*;
(
  input  logic             clk,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             inc_req,
  output logic [CNT_W-1:0] count,
  output logic             wrap_ev
);
  logic inc_taken;

  assign inc_taken = inc_req & ~wr_en;
  assign wrap_ev   = inc_taken & at_top(count);

  // deliberately no reset: the count survives reset
  always_ff @(posedge clk) begin
    if (wr_en)          count <= wr_val;
    else if (inc_taken) count <= bump(count);
  end
endmodule

// File: rtl/pa_regs.sv
module pa_regs
  import pa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap_set,
  input  logic              edge_set,
  output logic              wrap_flag,
  output logic              edge_flag,
  output logic [DATA_W-1:0] enab_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              flag_wr, enab_wr;
  logic [DATA_W-1:0] flag_view, rd_mux;

  assign flag_wr = bus_we && (reg_addr_e'(bus_addr) == RA_FLAG);
  assign enab_wr = bus_we && (reg_addr_e'(bus_addr) == RA_ENAB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_flag <= 1'b0;
      edge_flag <= 1'b0;
      enab_q    <= '0;
    end else begin
      wrap_flag <= flag_next(wrap_flag, wrap_set, flag_wr & bus_wdata[WRAP_BIT]);
      edge_flag <= flag_next(edge_flag, edge_set, flag_wr & bus_wdata[EDGE_BIT]);
      if (enab_wr) enab_q <= bus_wdata & ENAB_KEEP;
    end
  end

  always_comb begin
    flag_view           = '0;
    flag_view[WRAP_BIT] = wrap_flag;
    flag_view[EDGE_BIT] = edge_flag;
  end

  always_comb begin
    unique case (reg_addr_e'(bus_addr))
      RA_COUNT: rd_mux = DATA_W'(count);
      RA_ENAB:  rd_mux = enab_q;
      RA_FLAG:  rd_mux = flag_view;
      default:  rd_mux = '0;
    endcase
  end

  // reads captured on the half cycle opposite to count updates
  always_ff @(negedge clk) bus_rdata <= rd_mux;

  assign irq = (wrap_flag & enab_q[WRAP_BIT]) | (edge_flag & enab_q[EDGE_BIT]);
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TBASE_DIV   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              cfg_gated,
  input  logic              cfg_active_high,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              s_lvl, s_prev, tb_tick;
  logic              act_edge, trail_edge, gate_act;
  logic              inc_req, edge_ev, cnt_wr, wrap_ev;
  logic              wrap_flag, edge_flag;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] enab_q;

  pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl(s_lvl), .lvl_prev(s_prev)
  );

  pa_tbase #(.DIV(TBASE_DIV)) u_tbase (
    .clk(clk), .rst_n(rst_n), .tick(tb_tick)
  );

  assign act_edge   = pick_edge(s_lvl, s_prev, cfg_active_high);
  assign trail_edge = pick_edge(s_lvl, s_prev, ~cfg_active_high);
  assign gate_act   = gate_on(s_lvl, cfg_active_high);

  assign inc_req = cfg_gated ? (tb_tick & gate_act) : act_edge;
  assign edge_ev = cfg_gated ? trail_edge : act_edge;
  assign cnt_wr  = bus_we && (reg_addr_e'(bus_addr) == RA_COUNT);

  pa_counter u_cnt (
    .clk(clk), .wr_en(cnt_wr), .wr_val(bus_wdata[CNT_W-1:0]),
    .inc_req(inc_req), .count(count), .wrap_ev(wrap_ev)
  );

  pa_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count(count), .wrap_set(wrap_ev),
    .edge_set(edge_ev), .wrap_flag(wrap_flag), .edge_flag(edge_flag),
    .enab_q(enab_q), .bus_rdata(bus_rdata), .irq(irq)
  );
endmodule

// File: rtl/pa_checker.sv
module pa_checker
  import pa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  count,
  input logic              inc_req,
  input logic              edge_ev,
  input logic              wrap_flag,
  input logic              edge_flag,
  input logic [DATA_W-1:0] enab_q,
  input logic              irq
);
  logic cwr, fwr;
  assign cwr = bus_we && bus_addr == 2'd0;
  assign fwr = bus_we && bus_addr == 2'd2;

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> count == $past(bus_wdata[CNT_W-1:0])); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !cwr) |=> count == CNT_W'($past(count) + CNT_W'(1))); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_req && !cwr) |=> $stable(count)); // R4
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !cwr && count == '1) |=> wrap_flag); // R5
  AST_WRAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_flag && !(fwr && bus_wdata[WRAP_BIT])) |=> wrap_flag); // R6
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> edge_flag); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enab_q[WRAP_BIT] && !enab_q[EDGE_BIT]) |-> !irq); // R8
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && enab_q[EDGE_BIT]) |-> irq); // R8
  AST_ENAB_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_q[7:6] == 2'b00 && enab_q[3:2] == 2'b00)); // R9
endmodule

bind pulse_accum pa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .count(count), .inc_req(inc_req), .edge_ev(edge_ev),
  .wrap_flag(wrap_flag), .edge_flag(edge_flag), .enab_q(enab_q), .irq(irq)
);

// File: tb/sim_pulse_accum.sv
`timescale 1ns/1ps
module sim_pulse_accum;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0, cfg_gated = 1'b0, cfg_active_high = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  always #2.5 clk = ~clk;

  pulse_accum u0 (.*);

  int checks = 0, errors = 0;
  bit chk_on = 0, done = 0;

  // behavioural reference state
  int m_cnt = 0; bit m_known = 0;
  bit m_wrap = 0, m_edge = 0;
  int m_enab = 0, m_pre = 0;
  bit pin_q[$] = '{0, 0, 0};

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit cur, prev, rise, fall, aedge, tedge, lvl, inc, eev, ws, clr;
    if (!rst_n) begin
      m_wrap = 0; m_edge = 0; m_enab = 0; m_pre = 0;
      pin_q = '{0, 0, 0};
      return;
    end
    cur = pin_q[1]; prev = pin_q[2];
    rise = cur && !prev; fall = !cur && prev;
    aedge = cfg_active_high ? rise : fall;
    tedge = cfg_active_high ? fall : rise;
    lvl = (cur == cfg_active_high);
    inc = cfg_gated ? (m_pre == 63 && lvl) : aedge;
    eev = cfg_gated ? tedge : aedge;
    ws = 0;
    if (bus_we && bus_addr == 0) begin m_cnt = bus_wdata; m_known = 1; end
    else if (inc) begin
      if (m_cnt == 255) ws = 1;
      m_cnt = (m_cnt + 1) % 256;
    end
    clr = bus_we && bus_addr == 2;
    m_wrap = ws || (m_wrap && !(clr && bus_wdata[5]));
    m_edge = eev || (m_edge && !(clr && bus_wdata[4]));
    if (bus_we && bus_addr == 1) m_enab = bus_wdata & 8'h33;
    m_pre = (m_pre + 1) % 64;
    void'(pin_q.pop_back());
    pin_q.push_front(pin_in);
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return m_cnt;
      1: return m_enab;
      2: return (int'(m_wrap) << 5) | (int'(m_edge) << 4);
      default: return 0;
    endcase
  endfunction

  function automatic int m_irq();
    return int'((m_wrap && m_enab[5]) || (m_edge && m_enab[4]));
  endfunction

  always @(posedge clk) begin
    #0.5;
    model_step();
    if (chk_on && !done) chk("R8", "irq per cycle", int'(irq), m_irq());
  end

  always @(negedge clk) begin
    #0.5;
    if (chk_on && !done && !(bus_addr == 0 && !m_known))
      case (bus_addr)
        2'd0: chk("R10", "rdata count", int'(bus_rdata), m_read(0));
        2'd1: chk("R9", "rdata enab", int'(bus_rdata), m_read(1));
        2'd2: chk("R6", "rdata flags", int'(bus_rdata), m_read(2));
        default: chk("R9", "rdata spare", int'(bus_rdata), 0);
      endcase
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(int a, int d);
    bus_we = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
    cyc(1);
    bus_we = 0;
  endtask

  task automatic rd(int a, output int v);
    bus_addr = 2'(a);
    cyc(1);
    v = int'(bus_rdata);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      pin_in = ~pin_in; cyc(4);
      pin_in = ~pin_in; cyc(4);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, c0;
    cyc(4);
    rst_n = 1;
    cyc(1);
    chk_on = 1;
    rd(1, v); chk("R2", "enab after reset", v, 0);
    rd(2, v); chk("R2", "flags after reset", v, 0);
    chk("R8", "irq after reset", int'(irq), 0);

    wr(0, 8'hFC);
    rd(0, v); chk("R1", "count written", v, 8'hFC);

    // event mode, rising edges
    cfg_gated = 0; cfg_active_high = 1;
    pulse(3);
    rd(0, v); chk("R3", "three rising edges", v, 8'hFF);
    pulse(1);
    rd(0, v); chk("R5", "count wrapped", v, 8'h00);
    rd(2, v); chk("R5", "wrap flag", v & 8'h20, 8'h20);
    chk("R7", "edge flag event", v & 8'h10, 8'h10);
    chk("R8", "irq masked", int'(irq), 0);

    wr(1, 8'hFF);
    rd(1, v); chk("R9", "enab reserved bits", v, 8'h33);
    rd(2, v); chk("R8", "enab write keeps flags", v, 8'h30);
    chk("R8", "irq enabled", int'(irq), 1);

    wr(2, 8'h00);
    rd(2, v); chk("R6", "write zero keeps", v, 8'h30);
    wr(2, 8'h20);
    rd(2, v); chk("R6", "clear wrap only", v, 8'h10);
    wr(2, 8'h10);
    rd(2, v); chk("R6", "clear edge", v, 8'h00);
    chk("R8", "irq dropped", int'(irq), 0);

    // falling edges
    wr(0, 8'h10);
    cfg_active_high = 0;
    pulse(2);
    rd(0, v); chk("R3", "falling edges", v, 8'h12);
    rd(3, v); chk("R9", "spare address", v, 0);

    // reset keeps count
    wr(0, 8'h5A);
    chk_on = 0;
    rst_n = 0; cyc(3); rst_n = 1; cyc(1);
    chk_on = 1;
    rd(0, v); chk("R2", "count through reset", v, 8'h5A);
    rd(1, v); chk("R2", "enab cleared", v, 0);

    // gated mode, high active
    cfg_gated = 1; cfg_active_high = 1;
    wr(0, 0); wr(1, 8'h10);
    pin_in = 1; cyc(64 * 4 + 10);
    pin_in = 0; cyc(6);
    rd(0, v); chk("R4", "gated ticks", int'(v >= 4 && v <= 5), 1);
    rd(2, v); chk("R7", "trailing edge flag", v & 8'h10, 8'h10);
    chk("R8", "edge irq", int'(irq), 1);
    rd(0, c0); cyc(200);
    rd(0, v); chk("R4", "gate closed holds", v, c0);
    wr(2, 8'h10);

    // write beats increments across many ticks
    pin_in = 1; cyc(4);
    bus_we = 1; bus_addr = 0; bus_wdata = 8'h77;
    cyc(130);
    pin_in = 0; cyc(5);
    bus_we = 0;
    rd(0, v); chk("R1", "write priority", v, 8'h77);

    // set beats clear in the same cycle
    cfg_gated = 0; cfg_active_high = 1;
    cyc(4);
    pin_in = 1; cyc(2);
    wr(2, 8'h10);
    rd(2, v); chk("R6", "set wins over clear", v & 8'h10, 8'h10);
    pin_in = 0; cyc(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule